// File: doc/BRIEF.md
# Divided-Clock Bang-Bang Phase Comparator

This block judges whether a local oscillator runs ahead of or behind a reference clock. Both clocks are brought down to their greatest common divisor rate before the comparison. With a 10 MHz reference and a 155.52 MHz oscillator, that rate is 80 kHz: 1944 oscillator cycles or 125 reference cycles per comparison period. The block runs on the oscillator clock. It receives a one-cycle pulse for each synchronized reference edge. It also receives a bank of reference samples taken by flip-flops whose clocks are staggered in time around the comparison instant.

At each comparison instant the staggered samples are captured, reclocked once more on the oscillator clock and then decoded. In single-bit mode the decision is the sample at the centre tap: is the reference edge before or after the oscillator's instant? In multi-bit mode the samples form a thermometer code. The code is checked for monotonicity and turned into a signed phase step centred on zero. A second comparison half a period later, taken on the inverted reference, can be enabled to double the decision rate. The loop filter downstream takes the decisions at each strobe.

Top module: `divided_phase_comparator`

## Requirements
- R1: With the half-period comparison disabled, decision strobes follow each other exactly OSC_DIV (default 1944) oscillator cycles apart.
- R2: The reference divider counts REF_DIV (default 125) reference-edge pulses per period. Once the oscillator divider has already wrapped, the first decision comes only after the 125th reference pulse and within two oscillator periods of it.
- R3: After reset no decision or bubble flag is issued until both dividers have completed one full period. If reference pulses never arrive, the block never issues a decision.
- R4: In single-bit mode (multi_en=0), early_late equals tap TAPS/2 (tap 4 of 8) of the captured sample word. phase_code is +1 when early_late is 1 and -1 otherwise. No monotonicity check is applied, so every comparison gives a strobe.
- R5: In multi-bit mode, bit i of the sample word is tap i, and higher indices are later in time. therm_code reports the captured word. phase_code is the number of ones minus TAPS/2, as a two's complement value from -4 to +4 for 8 taps.
- R6: In multi-bit mode, a word is a bubble if some bit i is 1 while bit i+1 is 0. A bubble raises bubble for one cycle and gives no strobe, and therm_code, phase_code and early_late keep their previous values.
- R7: With dual_en=1, an extra comparison takes place OSC_DIV/2 (972) cycles after each main one. It uses the bitwise-inverted sample word and is marked by dec_half=1, so strobes come 972 cycles apart.
- R8: The sample word matters only at the comparison instant. Changes made between instants do not affect the next decision.
- R9: During and right after reset, dec_stb, dec_half, early_late, therm_code, phase_code and bubble are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | One-cycle pulse per synchronized reference edge |
| stag_smp | input | TAPS | Staggered reference samples, bit i is tap i (later taps at higher indices) |
| multi_en | input | 1 | 1 selects thermometer mode, 0 selects single-bit mode |
| dual_en | input | 1 | Enables the half-period comparison on the inverted reference |
| dec_stb | output | 1 | One-cycle strobe marking a new decision |
| dec_half | output | 1 | Latest decision came from the half-period comparison |
| early_late | output | 1 | 1 when the reference had already risen at the centre tap (oscillator late) |
| therm_code | output | TAPS | Captured sample word of the latest decision |
| phase_code | output | CW | Signed phase step of the latest decision |
| bubble | output | 1 | One-cycle flag for a rejected non-monotonic word |

## Verification
The bench starts the oscillator divider with no reference pulses and checks that no decision appears. A design that armed on the oscillator divider alone would issue decisions from a reference that is not there. It feeds a bubbled word directly after a valid one. A design that passed bubbles through would move phase_code to a false value instead of holding the previous step. It changes the sample word only between instants and checks the next decision, which catches capture logic that runs on every cycle. It also measures the strobe spacing with and without the half-period comparison and checks the sign of the inverted-word decision, which exposes a misplaced half instant or a missing inversion.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Which comparison produced a captured word.
  typedef enum logic {
    CMP_MAIN = 1'b0,
    CMP_HALF = 1'b1
  } cmp_kind_e;

  // Width of a signed code spanning -taps/2 .. +taps/2.
  function automatic int code_width(input int taps);
    return $clog2(taps) + 1;
  endfunction

endpackage

// File: rtl/dpc_osc_div.sv
module dpc_osc_div #(
  parameter int OSC_DIV = 1944
) (
  input  logic clk,
  input  logic rst,
  output logic inst_main,
  output logic inst_half,
  output logic seen
);
  localparam int CW   = $clog2(OSC_DIV);
  localparam int HALF = OSC_DIV / 2;
  localparam logic [CW-1:0] LAST  = CW'(OSC_DIV - 1);
  localparam logic [CW-1:0] HLAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      seen <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign inst_main = (cnt == LAST);
  assign inst_half = (cnt == HLAST);

  // R1: counter stays inside one period and restarts after the last count
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));
  // R3: the completed-period flag never drops outside reset
  a_r3_seen_sticky: assert property (@(posedge clk) disable iff (rst)
    seen |=> seen);
endmodule

// File: rtl/dpc_ref_div.sv
module dpc_ref_div #(
  parameter int REF_DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_edge,
  output logic seen
);
  localparam int CW = $clog2(REF_DIV);
  localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (ref_edge) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        seen <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the count moves only on reference pulses and wraps after REF_DIV of them
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !ref_edge |=> $stable(cnt));
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (ref_edge && cnt == LAST) |=> (cnt == '0 && seen));
  a_r2_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/dpc_therm_dec.sv
module dpc_therm_dec #(
  parameter int TAPS = 8,
  parameter int CW   = 4
) (
  input  logic [TAPS-1:0] smp,
  output logic            mono,
  output logic            centre,
  output logic [CW-1:0]   code
);
  localparam int OW = $clog2(TAPS + 1);

  logic [TAPS-2:0] brk;
  logic [OW-1:0]   ones;

  // A break is a tap that saw the reference high followed by a later tap that saw it low.
  for (genvar i = 0; i < TAPS - 1; i++) begin : g_brk
    assign brk[i] = smp[i] & ~smp[i+1];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + OW'(smp[i]);
    end
  end

  assign mono   = ~|brk;
  assign centre = smp[TAPS/2];
  assign code   = CW'(ones) - CW'(TAPS / 2);
endmodule

// File: rtl/divided_phase_comparator.sv
module divided_phase_comparator #(
  parameter int OSC_DIV = 1944,
  parameter int REF_DIV = 125,
  parameter int TAPS    = 8,
  localparam int CW     = dpc_pkg::code_width(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_edge,
  input  logic [TAPS-1:0]      stag_smp,
  input  logic                 multi_en,
  input  logic                 dual_en,
  output logic                 dec_stb,
  output logic                 dec_half,
  output logic                 early_late,
  output logic [TAPS-1:0]      therm_code,
  output logic signed [CW-1:0] phase_code,
  output logic                 bubble
);
  import dpc_pkg::*;

  localparam logic [CW-1:0] PLUS1  = CW'(1);
  localparam logic [CW-1:0] MINUS1 = {CW{1'b1}};
  localparam int            HALFT  = TAPS / 2;

  logic inst_main, inst_half, osc_seen, ref_seen;
  logic armed, take;

  dpc_osc_div #(.OSC_DIV(OSC_DIV)) u_osc (
    .clk(clk), .rst(rst),
    .inst_main(inst_main), .inst_half(inst_half), .seen(osc_seen)
  );

  dpc_ref_div #(.REF_DIV(REF_DIV)) u_ref (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .seen(ref_seen)
  );

  assign armed = osc_seen & ref_seen;
  assign take  = armed & (inst_main | (inst_half & dual_en));

  // Capture stage: first flop that sees the staggered samples
  logic            cap_vld;
  cmp_kind_e       cap_kind;
  logic [TAPS-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_kind <= CMP_MAIN;
      cap_q    <= '0;
    end else begin
      cap_vld <= take;
      if (take) begin
        cap_kind <= inst_half ? CMP_HALF : CMP_MAIN;
        cap_q    <= inst_half ? ~stag_smp : stag_smp;
      end
    end
  end

  // Reclock stage: keeps a metastable capture away from the decoder
  logic            rck_vld;
  cmp_kind_e       rck_kind;
  logic [TAPS-1:0] rck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rck_vld  <= 1'b0;
      rck_kind <= CMP_MAIN;
      rck_q    <= '0;
    end else begin
      rck_vld  <= cap_vld;
      rck_kind <= cap_kind;
      rck_q    <= cap_q;
    end
  end

  logic          d_mono, d_centre;
  logic [CW-1:0] d_code;

  dpc_therm_dec #(.TAPS(TAPS), .CW(CW)) u_dec (
    .smp(rck_q), .mono(d_mono), .centre(d_centre), .code(d_code)
  );

  // Output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_stb    <= 1'b0;
      dec_half   <= 1'b0;
      early_late <= 1'b0;
      therm_code <= '0;
      phase_code <= '0;
      bubble     <= 1'b0;
    end else begin
      dec_stb <= 1'b0;
      bubble  <= 1'b0;
      if (rck_vld) begin
        if (multi_en && !d_mono) begin
          bubble <= 1'b1;
        end else begin
          dec_stb    <= 1'b1;
          dec_half   <= (rck_kind == CMP_HALF);
          early_late <= d_centre;
          therm_code <= rck_q;
          phase_code <= multi_en ? d_code : (d_centre ? PLUS1 : MINUS1);
        end
      end
    end
  end

  // R3: no output event before both dividers completed a period
  a_r3_osc_armed: assert property (@(posedge clk) disable iff (rst)
    !osc_seen |-> !(dec_stb || bubble));
  a_r3_ref_armed: assert property (@(posedge clk) disable iff (rst)
    !ref_seen |-> !(dec_stb || bubble));
  // R6: a rejected word never coincides with a strobe, and the step holds between strobes
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dec_stb && bubble));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !dec_stb |-> $stable(phase_code) && $stable(therm_code));
  // R5: every reported step lies inside the thermometer span
  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    dec_stb |-> (phase_code >= -HALFT) && (phase_code <= HALFT));
  // R7: a half-period decision only comes from a comparison taken while enabled
  a_r7_half_enabled: assert property (@(posedge clk) disable iff (rst)
    (dec_stb && dec_half) |-> $past(dual_en, 2));
endmodule

// File: tb/divided_phase_comparator_test.sv
module divided_phase_comparator_test;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_DIV    = 1944;
  localparam int REF_DIV    = 125;
  localparam int TAPS       = 8;
  localparam int CW         = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 ref_edge = 1'b0;
  logic [TAPS-1:0]      stag_smp = 8'hF0;
  logic                 multi_en = 1'b1;
  logic                 dual_en  = 1'b0;
  logic                 dec_stb, dec_half, early_late, bubble;
  logic [TAPS-1:0]      therm_code;
  logic signed [CW-1:0] phase_code;

  int  checks = 0;
  int  errors = 0;
  int  cyc    = 0;
  bit  ref_run = 1'b0;
  int  acc = 0;

  divided_phase_comparator #(.OSC_DIV(OSC_DIV), .REF_DIV(REF_DIV), .TAPS(TAPS)) uut (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .stag_smp(stag_smp),
    .multi_en(multi_en), .dual_en(dual_en), .dec_stb(dec_stb),
    .dec_half(dec_half), .early_late(early_late), .therm_code(therm_code),
    .phase_code(phase_code), .bubble(bubble)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference pulses: exactly REF_DIV per OSC_DIV oscillator cycles
  initial begin
    forever begin
      @(negedge clk);
      if (ref_run) begin
        acc = acc + REF_DIV;
        if (acc >= OSC_DIV) begin
          acc = acc - OSC_DIV;
          ref_edge = 1'b1;
        end else begin
          ref_edge = 1'b0;
        end
      end else begin
        ref_edge = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for a strobe or a bubble flag; returns the cycle it was seen on
  task automatic wait_evt(output bit found, output int at);
    found = 1'b0;
    at = 0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (dec_stb || bubble) begin
        found = 1'b1;
        at = cyc;
        break;
      end
    end
  endtask

  task automatic run_cycles(input int n, output int events);
    events = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dec_stb || bubble) events++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dec_stb == 0 && bubble == 0 && dec_half == 0, "R9 flags", {dec_stb, bubble, dec_half}, 0);
    chk(therm_code == 0 && early_late == 0, "R9 therm", therm_code, 0);
    chk(phase_code == 0, "R9 code", phase_code, 0);
  endtask

  task automatic t_startup();
    int ev; bit f; int at; int t0;
    rst = 1'b0;
    run_cycles(3 * OSC_DIV, ev);
    chk(ev == 0, "R3 no reference pulses", ev, 0);
    ref_run = 1'b1;
    t0 = cyc;
    run_cycles(1900, ev);
    chk(ev == 0, "R2 before 125th pulse", ev, 0);
    wait_evt(f, at);
    chk(f && dec_stb, "R2 first decision", f, 1);
    chk((at - t0) < 2 * OSC_DIV + 8, "R2 first decision timing", at - t0, 2 * OSC_DIV);
  endtask

  task automatic t_interval();
    bit f; int a0; int a1;
    wait_evt(f, a0);
    wait_evt(f, a1);
    chk(f && (a1 - a0) == OSC_DIV, "R1 strobe spacing", a1 - a0, OSC_DIV);
  endtask

  task automatic t_multi(input logic [7:0] w, input int exp_code);
    bit f; int at;
    stag_smp = w;
    wait_evt(f, at);
    wait_evt(f, at);
    chk(f && dec_stb, "R5 strobe", dec_stb, 1);
    chk(therm_code == w, "R5 therm_code", therm_code, w);
    chk(int'(phase_code) == exp_code, "R5 phase_code", phase_code, exp_code);
  endtask

  task automatic t_bubble();
    bit f; int at;
    stag_smp = 8'hE0;
    wait_evt(f, at);
    wait_evt(f, at);
    chk(int'(phase_code) == -1, "R6 setup code", phase_code, -1);
    stag_smp = 8'hB0;
    wait_evt(f, at);
    chk(f && bubble == 1 && dec_stb == 0, "R6 bubble flag", {bubble, dec_stb}, 2);
    chk(int'(phase_code) == -1, "R6 code held", phase_code, -1);
    chk(therm_code == 8'hE0, "R6 therm held", therm_code, 8'hE0);
    stag_smp = 8'hF0;
    wait_evt(f, at);
  endtask

  task automatic t_single();
    bit f; int at;
    multi_en = 1'b0;
    stag_smp = 8'hF0;
    wait_evt(f, at);
    chk(f && dec_stb && early_late == 1, "R4 late bit", early_late, 1);
    chk(int'(phase_code) == 1, "R4 plus one", phase_code, 1);
    stag_smp = 8'h0F;
    wait_evt(f, at);
    chk(f && dec_stb == 1 && bubble == 0, "R4 no bubble check", dec_stb, 1);
    chk(early_late == 0 && int'(phase_code) == -1, "R4 minus one", phase_code, -1);
    multi_en = 1'b1;
    stag_smp = 8'hF0;
    wait_evt(f, at);
  endtask

  task automatic t_ignore();
    bit f; int at;
    stag_smp = 8'hF0;
    wait_evt(f, at);
    repeat (100) @(negedge clk);
    stag_smp = 8'hFF;
    repeat (100) @(negedge clk);
    stag_smp = 8'hF0;
    wait_evt(f, at);
    chk(f && therm_code == 8'hF0, "R8 between-instant change ignored", therm_code, 8'hF0);
    chk(int'(phase_code) == 0, "R8 code", phase_code, 0);
  endtask

  task automatic t_dual();
    bit f; int a0; int a1; int a2;
    stag_smp = 8'h00;
    wait_evt(f, a0);
    dual_en = 1'b1;
    wait_evt(f, a1);
    chk(f && dec_half == 1, "R7 half marked", dec_half, 1);
    chk((a1 - a0) == OSC_DIV / 2, "R7 half spacing", a1 - a0, OSC_DIV / 2);
    chk(int'(phase_code) == 4 && therm_code == 8'hFF, "R7 inverted word", phase_code, 4);
    wait_evt(f, a2);
    chk(f && dec_half == 0 && int'(phase_code) == -4, "R7 main after half", phase_code, -4);
    chk((a2 - a1) == OSC_DIV / 2, "R7 main spacing", a2 - a1, OSC_DIV / 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_startup();
    t_interval();
    t_multi(8'hF0, 0);
    t_multi(8'hFF, 4);
    t_multi(8'h00, -4);
    t_multi(8'hFE, 3);
    t_multi(8'hC0, -2);
    t_bubble();
    t_single();
    t_ignore();
    t_dual();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule